// File: doc/BRIEF.md
# Mailbox Handshake Receiver

This block sits on the host side of a one-deep message mailbox shared with an embedded training microcontroller. Two flags guard the mailbox. The controller drops its flag to 0 to say that a message is waiting. The host drops its own flag to 0 to acknowledge the message. The controller then raises its flag again, and the host raises its flag to close the exchange. Every message therefore takes four flag transitions. When the exchange is complete, the receiver presents the message as a 32-bit word with a one-cycle valid strobe.

A run begins with a start pulse, which also latches two options. Streaming mode captures a second 16-bit data word alongside the 16-bit major message. Loop mode keeps the receiver collecting messages until a terminal code arrives: training passed (0x0007) or training failed (0x00FF). A per-wait cycle limit protects each exchange. If the controller never moves its flag, the receiver sets a sticky error and returns to idle.

Top module: `mbx_rx_top`

## Requirements
- R1: After reset, host_prot_o is 1, and msg_valid_o, done_o, pass_o and timeout_err_o are 0.
- R2: After a start pulse, host_prot_o stays 1 for as long as ctl_prot_i reads 1 (no message pending).
- R3: The first rising clock edge at which ctl_prot_i reads 0 in the pending wait does two things. It captures ctl_msg_i into msg_o[15:0], and it drives host_prot_o to 0. Input changes after that edge do not alter the captured message.
- R4: stream_i is latched with the start pulse. When it is 1, ctl_data_i is captured into msg_o[31:16] at the same edge. When it is 0, msg_o[31:16] is 0.
- R5: host_prot_o stays 0 while ctl_prot_i stays 0. It returns to 1 at the first edge at which ctl_prot_i reads 1.
- R6: msg_valid_o is high for exactly one cycle: the first cycle in which host_prot_o is back at 1 after an acknowledge. msg_o holds the assembled message in that cycle.
- R7: loop_i is latched with the start pulse. With loop_i=1, the receiver returns to the pending wait after each message. It stops only when msg_o[15:0] is exactly 0x0007 or 0x00FF. With loop_i=0 it goes idle after one message. When idle, a pending flag is never acknowledged.
- R8: done_o is high together with msg_valid_o when msg_o[15:0] is 0x0007 or 0x00FF. pass_o is high only for 0x0007.
- R9: TIMEOUT_CYCLES consecutive cycles in one wait state without the awaited flag level cause four things: timeout_err_o is set, host_prot_o is forced to 1, the receiver goes idle, and timeout_err_o stays set until reset. A value of 0 disables the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| loop_i | input | 1 | Loop until a terminal code (latched at start) |
| stream_i | input | 1 | Capture the second data word (latched at start) |
| ctl_prot_i | input | 1 | Controller protect flag; 0 means a message is pending |
| ctl_msg_i | input | WORD_W | Controller major message word |
| ctl_data_i | input | WORD_W | Controller streaming data word |
| host_prot_o | output | 1 | Host protect flag; 0 acknowledges a message |
| msg_o | output | 2*WORD_W | Assembled message, data word in the upper half |
| msg_valid_o | output | 1 | One-cycle message strobe |
| done_o | output | 1 | Terminal code seen with this message |
| pass_o | output | 1 | Terminal code is the pass code |
| timeout_err_o | output | 1 | Sticky wait-limit error |

## Verification
The bound checker watches the flag ordering on every cycle. The host flag may fall only after the controller flag read 0. It may rise only after the controller flag read 1, or on a timeout. The strobe always lasts one cycle and follows an acknowledge. The message changes only at the acknowledge edge, done and pass nest inside the strobe, and the error flag never clears on its own. Some behaviours depend on the latched modes and on exact cycle counts, and only the bench scenarios can show them. These are the upper-half zeroing, loop termination on full 16-bit codes such as 0x0107, that nothing is acknowledged once a run ends, and the exact cycle at which each wait limit expires.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_PEND = 2'd1,
    ST_WAIT_REL  = 2'd2,
    ST_EMIT      = 2'd3
  } mbx_state_e;

  localparam logic [15:0] MSG_TRAIN_PASS   = 16'h0007;
  localparam logic [15:0] MSG_TRAIN_FAIL   = 16'h00FF;
  localparam logic [15:0] MSG_STREAM_START = 16'h0008;
endpackage

// File: rtl/mbx_wait_timer.sv
`timescale 1ns/1ps
module mbx_wait_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic clr_i,
  output logic expire_o
);
  generate
    if (LIMIT == 0) begin : g_off
      logic unused_w;
      assign unused_w = clk_i ^ rst_ni ^ active_i ^ clr_i;
      assign expire_o = 1'b0;
    end else begin : g_on
      localparam int unsigned CNT_W = $clog2(LIMIT + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
      logic [CNT_W-1:0] cnt_q;

      assign expire_o = active_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (clr_i || !active_i) cnt_q <= '0;
        else if (!expire_o)         cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/mbx_word_capture.sv
`timescale 1ns/1ps
module mbx_word_capture #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  stream_i,
  input  logic [WORD_W-1:0]     lo_i,
  input  logic [WORD_W-1:0]     hi_i,
  output logic [2*WORD_W-1:0]   msg_o
);
  logic [WORD_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      lo_q <= lo_i;
      hi_q <= stream_i ? hi_i : '0;
    end
  end

  assign msg_o = {hi_q, lo_q};
endmodule

// File: rtl/mbx_term_detect.sv
`timescale 1ns/1ps
module mbx_term_detect #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] major_i,
  output logic              term_o,
  output logic              pass_o
);
  localparam logic [WORD_W-1:0] CODE_OK  = WORD_W'(mbx_pkg::MSG_TRAIN_PASS);
  localparam logic [WORD_W-1:0] CODE_BAD = WORD_W'(mbx_pkg::MSG_TRAIN_FAIL);

  assign pass_o = (major_i == CODE_OK);
  assign term_o = pass_o || (major_i == CODE_BAD);
endmodule

// File: rtl/mbx_rx_top.sv
`timescale 1ns/1ps
module mbx_rx_top #(
  parameter int unsigned WORD_W         = 16,
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                loop_i,
  input  logic                stream_i,
  input  logic                ctl_prot_i,
  input  logic [WORD_W-1:0]   ctl_msg_i,
  input  logic [WORD_W-1:0]   ctl_data_i,
  output logic                host_prot_o,
  output logic [2*WORD_W-1:0] msg_o,
  output logic                msg_valid_o,
  output logic                done_o,
  output logic                pass_o,
  output logic                timeout_err_o
);
  import mbx_pkg::*;

  mbx_state_e state_q, state_d;
  logic loop_q, stream_q, host_prot_q, tmo_q;
  logic in_wait, expire, capture, tmo_hit;
  logic term, pass;

  assign in_wait = (state_q == ST_WAIT_PEND) || (state_q == ST_WAIT_REL);

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    tmo_hit = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_WAIT_PEND;
      ST_WAIT_PEND: begin
        if (!ctl_prot_i) begin
          capture = 1'b1;
          state_d = ST_WAIT_REL;
        end else if (expire) begin
          tmo_hit = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_REL: begin
        if (ctl_prot_i) state_d = ST_EMIT;
        else if (expire) begin
          tmo_hit = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_EMIT:      state_d = (loop_q && !term) ? ST_WAIT_PEND : ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      loop_q      <= 1'b0;
      stream_q    <= 1'b0;
      host_prot_q <= 1'b1;
      tmo_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      host_prot_q <= (state_d != ST_WAIT_REL);
      if (tmo_hit) tmo_q <= 1'b1;
      if (state_q == ST_IDLE && start_i) begin
        loop_q   <= loop_i;
        stream_q <= stream_i;
      end
    end
  end

  mbx_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (in_wait),
    .clr_i    (state_d != state_q),
    .expire_o (expire)
  );

  mbx_word_capture #(.WORD_W(WORD_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (capture),
    .stream_i (stream_q),
    .lo_i     (ctl_msg_i),
    .hi_i     (ctl_data_i),
    .msg_o    (msg_o)
  );

  mbx_term_detect #(.WORD_W(WORD_W)) u_term (
    .major_i (msg_o[WORD_W-1:0]),
    .term_o  (term),
    .pass_o  (pass)
  );

  assign host_prot_o   = host_prot_q;
  assign msg_valid_o   = (state_q == ST_EMIT);
  assign done_o        = msg_valid_o && term;
  assign pass_o        = msg_valid_o && pass;
  assign timeout_err_o = tmo_q;
endmodule

// File: rtl/mbx_rx_chk.sv
`timescale 1ns/1ps
module mbx_rx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ctl_prot_i,
  input logic                host_prot_o,
  input logic [2*WORD_W-1:0] msg_o,
  input logic                msg_valid_o,
  input logic                done_o,
  input logic                pass_o,
  input logic                timeout_err_o
);
  p_ack_needs_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_prot_o) |-> $past(!ctl_prot_i));

  p_msg_changes_at_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(msg_o) |-> $fell(host_prot_o));

  p_release_needs_ctl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_prot_o) |-> ($past(ctl_prot_i) || timeout_err_o));

  p_valid_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o);

  p_valid_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (host_prot_o && $past(!host_prot_o)));

  p_done_in_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> msg_valid_o);

  p_pass_in_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);

  p_tmo_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_err_o |=> timeout_err_o);
endmodule

bind mbx_rx_top mbx_rx_chk #(.WORD_W(WORD_W)) u_mbx_rx_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctl_prot_i    (ctl_prot_i),
  .host_prot_o   (host_prot_o),
  .msg_o         (msg_o),
  .msg_valid_o   (msg_valid_o),
  .done_o        (done_o),
  .pass_o        (pass_o),
  .timeout_err_o (timeout_err_o)
);

// File: tb/mbx_rx_top_tb_top.sv
`timescale 1ns/1ps
module mbx_rx_top_tb_top;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, loop_i = 1'b0, stream_i = 1'b0;
  logic ctl_prot_i = 1'b1;
  logic [15:0] ctl_msg_i = '0, ctl_data_i = '0;
  logic host_prot_o, msg_valid_o, done_o, pass_o, timeout_err_o;
  logic [31:0] msg_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mbx_rx_top #(.WORD_W(16), .TIMEOUT_CYCLES(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .loop_i(loop_i),
    .stream_i(stream_i), .ctl_prot_i(ctl_prot_i), .ctl_msg_i(ctl_msg_i),
    .ctl_data_i(ctl_data_i), .host_prot_o(host_prot_o), .msg_o(msg_o),
    .msg_valid_o(msg_valid_o), .done_o(done_o), .pass_o(pass_o),
    .timeout_err_o(timeout_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_msg(input logic [15:0] lo, input logic [15:0] hi,
                                          input bit strm);
    return strm ? {hi, lo} : {16'h0000, lo};
  endfunction

  function automatic bit is_term(input logic [15:0] lo);
    return (lo == 16'h0007) || (lo == 16'h00FF);
  endfunction

  function automatic logic [15:0] rand_nonterm();
    logic [15:0] v;
    v = 16'($urandom);
    if (is_term(v)) v = v ^ 16'h0100;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ctl_prot_i = 1'b1;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(host_prot_o == 1'b1, "R1 host flag", 32'(host_prot_o), 1);
    chk({msg_valid_o, done_o, pass_o, timeout_err_o} == 4'b0, "R1 outputs idle",
        32'({msg_valid_o, done_o, pass_o, timeout_err_o}), 0);
  endtask

  task automatic start_run(input bit lp, input bit strm);
    start_i = 1'b1;
    loop_i = lp;
    stream_i = strm;
    @(negedge clk);
    start_i = 1'b0;
    loop_i = ~lp;
    stream_i = ~strm;
  endtask

  // controller side of one four-phase exchange, entered and left at a negedge
  task automatic send_msg(input logic [15:0] lo, input logic [15:0] hi, input bit strm,
                          input int pre, input int rel);
    for (int i = 0; i < pre; i++) begin
      chk(host_prot_o == 1'b1, "R2 no ack while nothing pending", 32'(host_prot_o), 1);
      @(negedge clk);
    end
    ctl_msg_i = lo;
    ctl_data_i = hi;
    ctl_prot_i = 1'b0;
    @(negedge clk);
    chk(host_prot_o == 1'b0, "R3 ack after pending", 32'(host_prot_o), 0);
    ctl_msg_i = ~lo;
    ctl_data_i = ~hi;
    for (int i = 0; i < rel; i++) begin
      @(negedge clk);
      chk(host_prot_o == 1'b0, "R5 ack held", 32'(host_prot_o), 0);
    end
    ctl_prot_i = 1'b1;
    @(negedge clk);
    chk(host_prot_o == 1'b1, "R5 host flag restored", 32'(host_prot_o), 1);
    chk(msg_valid_o == 1'b1, "R6 valid strobe", 32'(msg_valid_o), 1);
    chk(msg_o == exp_msg(lo, hi, strm), "R4 R3 message content", msg_o, exp_msg(lo, hi, strm));
    chk(done_o == is_term(lo), "R8 done", 32'(done_o), 32'(is_term(lo)));
    chk(pass_o == (lo == 16'h0007), "R8 pass", 32'(pass_o), 32'(lo == 16'h0007));
    @(negedge clk);
    chk(msg_valid_o == 1'b0, "R6 single cycle valid", 32'(msg_valid_o), 0);
  endtask

  task automatic check_idle(input int n);
    ctl_prot_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(host_prot_o == 1'b1, "R7 idle ignores pending", 32'(host_prot_o), 1);
    end
    ctl_prot_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();

    // single, non-stream
    start_run(1'b0, 1'b0);
    send_msg(16'h1234, 16'hABCD, 1'b0, 3, 0);
    check_idle(4);

    // single, stream, stream-start code
    start_run(1'b0, 1'b1);
    send_msg(16'h0008, 16'hBEEF, 1'b1, 1, 2);
    check_idle(2);

    // single, fail code
    start_run(1'b0, 1'b0);
    send_msg(16'h00FF, 16'h1111, 1'b0, 0, 1);
    check_idle(2);

    // loop: near-terminal codes must not stop the run (R7)
    start_run(1'b1, 1'b1);
    send_msg(16'h0107, 16'h0001, 1'b1, 0, 0);
    send_msg(16'hFF00, 16'h0002, 1'b1, 2, 0);
    send_msg(16'h0007, 16'h0003, 1'b1, 1, 3);
    check_idle(3);

    // constrained random loop runs
    for (int run = 0; run < 8; run++) begin
      bit strm;
      int nmsg;
      strm = 1'($urandom);
      nmsg = 1 + int'($urandom_range(0, 4));
      start_run(1'b1, strm);
      for (int m = 0; m < nmsg; m++)
        send_msg(rand_nonterm(), 16'($urandom), strm,
                 int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
      send_msg(($urandom_range(0, 1) != 0) ? 16'h0007 : 16'h00FF, 16'($urandom), strm,
               int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      check_idle(2);
    end

    // R9: pending wait expires
    start_run(1'b0, 1'b0);
    repeat (TMO - 1) @(negedge clk);
    chk(timeout_err_o == 1'b0, "R9 no timeout before limit", 32'(timeout_err_o), 0);
    @(negedge clk);
    chk(timeout_err_o == 1'b1, "R9 timeout at limit", 32'(timeout_err_o), 1);
    check_idle(2);
    start_run(1'b0, 1'b0);
    send_msg(16'h4321, 16'h0, 1'b0, 0, 0);
    chk(timeout_err_o == 1'b1, "R9 sticky", 32'(timeout_err_o), 1);

    // R9: release wait expires
    do_reset();
    start_run(1'b0, 1'b0);
    ctl_msg_i = 16'h0055;
    ctl_prot_i = 1'b0;
    @(negedge clk);
    repeat (TMO - 1) @(negedge clk);
    chk(host_prot_o == 1'b0, "R9 ack held before limit", 32'(host_prot_o), 0);
    chk(timeout_err_o == 1'b0, "R9 no early release timeout", 32'(timeout_err_o), 0);
    @(negedge clk);
    chk(host_prot_o == 1'b1, "R9 host flag forced high", 32'(host_prot_o), 1);
    chk(timeout_err_o == 1'b1, "R9 release timeout", 32'(timeout_err_o), 1);
    chk(msg_valid_o == 1'b0, "R9 no strobe on timeout", 32'(msg_valid_o), 0);
    ctl_prot_i = 1'b1;
    @(negedge clk);
    do_reset();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule